// File: doc/BRIEF.md
# Page Entry Permission Checker

This block judges a single leaf or pointer entry of a two-level-or-deeper page table against one memory access. Its inputs are the entry's 8-bit flag byte, the kind of access, the privilege of the requester, two control bits, and two fault indications from the table walker. The two control bits are one that lets executable pages be read, and one that lets supervisor code touch user pages. The block classifies the entry as invalid, as a pointer to the next table level, or as a leaf. For a leaf it decides whether the access is permitted. It computes whether the accessed or dirty flags must be written back, and gives the updated flag byte.

When the access cannot complete, the block picks one fault reason by a fixed priority. It then maps that reason, together with the access kind, to an architectural exception class. A table walker presents one entry per cycle with a valid strobe. All results appear in registers one cycle later, together with a matching valid output. Machine-level requests are not meant to reach this block. If one does, the block flags an internal error and denies the access.

Top module: `pte_perm_checker`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every output register is cleared, so `out_valid`, `allowed_o`, `new_flags_o`, `reason_o` and `exc_class_o` read 0 afterwards.
- R2: `out_valid` equals `in_valid` from the previous rising edge. All other outputs show the result for the inputs presented with that strobe.
- R3: Flag bit positions are D=7, A=6, G=5, U=4, X=3, W=2, R=1, V=0. `invalid_o` is 1 when V is 0, or when W is 1 while R is 0.
- R4: `pointer_o` is 1 when R, W and X are all 0. A valid pointer entry is never allowed, and it faults only on a memory error.
- R5: Access kind encoding is 0 read, 1 write, 2 read-modify-write and 3 execute. Privilege encoding is 0 user and 1 supervisor. For a user request, U must be 1. A read also needs R=1, or X=1 with the execute-readable bit set. A write needs W=1. A read-modify-write needs both the read and the write conditions. An execute needs X=1.
- R6: A supervisor read, write or read-modify-write needs U=0 or the supervisor-user bit set, plus the same R/W/X condition as R5. A supervisor execute needs U=0 and X=1, whatever the supervisor-user bit holds.
- R7: With the execute-readable bit clear, an entry with X=1 and R=0 is not readable at either privilege.
- R8: An update is needed when A=0, or when the access is a write or read-modify-write and D=0. `need_update_o` is set only for an allowed access that needs one. `new_flags_o` is the flag byte with A set, and with D also set for write and read-modify-write.
- R9: Reason codes are 0 none, 1 memory error, 2 invalid entry, 3 no permission, 4 misaligned superpage, and 5 update needed while updates are disabled. When several reasons apply, the lowest nonzero code wins. `allowed_o` is 1 exactly when privilege is user or supervisor, the entry is a leaf, and the reason is 0.
- R10: Class codes are 0 none, 1 load access, 2 load page, 3 store access, 4 store page, 5 fetch access and 6 fetch page. A memory error gives the access class and any other reason gives the page class. Read selects load, write and read-modify-write select store, and execute selects fetch.
- R11: Privilege 2 or 3 sets `internal_err_o`. It gives `allowed_o`=0, `need_update_o`=0, reason 0 and class 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input strobe |
| pte_flags_i | input | 8 | Entry flag byte |
| access_i | input | 2 | Access kind |
| priv_i | input | 2 | Requester privilege |
| exec_readable_i | input | 1 | Executable pages may be read |
| sup_user_i | input | 1 | Supervisor may touch user pages |
| upd_en_i | input | 1 | Flag write-back permitted |
| mem_err_i | input | 1 | Walker memory error on this entry |
| misalign_i | input | 1 | Walker found misaligned superpage |
| out_valid | output | 1 | Result strobe |
| invalid_o | output | 1 | Entry invalid |
| pointer_o | output | 1 | Entry points to next level |
| allowed_o | output | 1 | Access permitted |
| need_update_o | output | 1 | A/D write-back required |
| new_flags_o | output | 8 | Updated flag byte |
| reason_o | output | 3 | Fault reason code |
| exc_class_o | output | 3 | Exception class code |
| internal_err_o | output | 1 | Machine privilege presented |

## Verification
The hardest reason code to reach is 5. It needs a valid leaf whose permission check passes. It also needs no memory error and no misalignment, an A or D flag that requires write-back, and updates disabled, all in the same strobe. The bench sweeps every flag byte against every access kind, privilege and control-bit pair. Over this sweep, the update-enable input and the two walker fault inputs run on patterns that are coprime with the sweep. As a result, every such leaf is met with updates both off and on, and the lower-priority reasons are also reached under the higher ones.

// File: rtl/pte_chk_pkg.sv
// Package: shared widths, flag bit positions and code types for the
// page entry permission checker. Assumes the 8-bit flag layout is fixed.
package pte_chk_pkg;
    localparam int FLAG_W   = 8;
    localparam int ACC_W    = 2;
    localparam int PRIV_W   = 2;
    localparam int REASON_W = 3;
    localparam int CLASS_W  = 3;

    localparam int FB_V = 0;
    localparam int FB_R = 1;
    localparam int FB_W = 2;
    localparam int FB_X = 3;
    localparam int FB_U = 4;
    localparam int FB_G = 5;
    localparam int FB_A = 6;
    localparam int FB_D = 7;

    typedef enum logic [ACC_W-1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_RMW   = 2'd2,
        ACC_EXEC  = 2'd3
    } acc_e;

    typedef enum logic [REASON_W-1:0] {
        RSN_NONE     = 3'd0,
        RSN_MEM      = 3'd1,
        RSN_INVALID  = 3'd2,
        RSN_NOPERM   = 3'd3,
        RSN_MISALIGN = 3'd4,
        RSN_UPD_OFF  = 3'd5
    } reason_e;

    typedef enum logic [CLASS_W-1:0] {
        EXC_NONE   = 3'd0,
        EXC_LD_ACC = 3'd1,
        EXC_LD_PG  = 3'd2,
        EXC_ST_ACC = 3'd3,
        EXC_ST_PG  = 3'd4,
        EXC_IF_ACC = 3'd5,
        EXC_IF_PG  = 3'd6
    } exc_e;
endpackage

// File: rtl/pte_flag_decode.sv
// Module: classifies an entry from its V/R/W/X bits as invalid or as a
// pointer to the next level. Purely combinational; assumes no other bits
// influence the classification.
module pte_flag_decode (
    input  logic v_i,
    input  logic r_i,
    input  logic w_i,
    input  logic x_i,
    output logic invalid_o,
    output logic pointer_o
);
    // Invalid: not present, or writable without being readable.
    always_comb begin
        invalid_o = !v_i || (w_i && !r_i);
    end

    // Pointer: no access rights at all on this entry.
    always_comb begin
        pointer_o = !r_i && !w_i && !x_i;
    end
endmodule

// File: rtl/pte_access_rules.sv
// Module: evaluates the permission rules for one access kind at user or
// supervisor level. Assumes machine level is filtered by the caller.
module pte_access_rules
    import pte_chk_pkg::*;
(
    input  acc_e acc_i,
    input  logic is_user_i,
    input  logic exec_readable_i,
    input  logic sup_user_i,
    input  logic u_i,
    input  logic x_i,
    input  logic w_i,
    input  logic r_i,
    output logic permit_o
);
    logic readable;
    logic owner_ok;
    logic exec_owner_ok;

    // Read right, widened to executable pages when the override is on.
    always_comb begin
        readable = r_i || (x_i && exec_readable_i);
    end

    // Ownership for data accesses and for instruction fetch.
    always_comb begin
        owner_ok      = is_user_i ? u_i : (!u_i || sup_user_i);
        exec_owner_ok = is_user_i ? u_i : !u_i;
    end

    // Combine ownership with the right that the access kind needs.
    always_comb begin
        unique case (acc_i)
            ACC_READ:  permit_o = owner_ok && readable;
            ACC_WRITE: permit_o = owner_ok && w_i;
            ACC_RMW:   permit_o = owner_ok && w_i && readable;
            ACC_EXEC:  permit_o = exec_owner_ok && x_i;
            default:   permit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/pte_dirty_update.sv
// Module: decides whether the accessed/dirty flags need write-back and
// forms the updated flag byte. Assumes the caller gates the need by
// permission; the byte itself is valid for any access.
module pte_dirty_update
    import pte_chk_pkg::*;
#(
    parameter int WIDTH = FLAG_W
) (
    input  logic [WIDTH-1:0] flags_i,
    input  acc_e             acc_i,
    output logic             upd_needed_o,
    output logic [WIDTH-1:0] new_flags_o
);
    logic is_store;

    // Writes and read-modify-writes dirty the page.
    always_comb begin
        is_store = (acc_i == ACC_WRITE) || (acc_i == ACC_RMW);
    end

    // Need write-back when A is clear or a store meets a clean page.
    always_comb begin
        upd_needed_o = !flags_i[FB_A] || (is_store && !flags_i[FB_D]);
    end

    // Updated byte: A always set, D set for stores.
    always_comb begin
        new_flags_o        = flags_i;
        new_flags_o[FB_A]  = 1'b1;
        if (is_store) begin
            new_flags_o[FB_D] = 1'b1;
        end
    end
endmodule

// File: rtl/pte_fault_select.sv
// Module: picks the winning fault reason by fixed priority and maps it
// with the access kind to an exception class. Assumes the permission and
// update inputs are meaningful only for leaf entries.
module pte_fault_select
    import pte_chk_pkg::*;
(
    input  acc_e    acc_i,
    input  logic    mach_i,
    input  logic    mem_err_i,
    input  logic    invalid_i,
    input  logic    pointer_i,
    input  logic    permit_i,
    input  logic    misalign_i,
    input  logic    upd_needed_i,
    input  logic    upd_en_i,
    output reason_e reason_o,
    output exc_e    exc_o
);
    // Priority chain: lowest code wins; pointers stop before leaf checks.
    always_comb begin
        if (mach_i)                        reason_o = RSN_NONE;
        else if (mem_err_i)                reason_o = RSN_MEM;
        else if (invalid_i)                reason_o = RSN_INVALID;
        else if (pointer_i)                reason_o = RSN_NONE;
        else if (!permit_i)                reason_o = RSN_NOPERM;
        else if (misalign_i)               reason_o = RSN_MISALIGN;
        else if (upd_needed_i && !upd_en_i) reason_o = RSN_UPD_OFF;
        else                               reason_o = RSN_NONE;
    end

    // Class: access fault for memory errors, page fault otherwise.
    always_comb begin
        if (reason_o == RSN_NONE) begin
            exc_o = EXC_NONE;
        end else begin
            unique case (acc_i)
                ACC_READ:          exc_o = (reason_o == RSN_MEM) ? EXC_LD_ACC : EXC_LD_PG;
                ACC_WRITE, ACC_RMW: exc_o = (reason_o == RSN_MEM) ? EXC_ST_ACC : EXC_ST_PG;
                ACC_EXEC:          exc_o = (reason_o == RSN_MEM) ? EXC_IF_ACC : EXC_IF_PG;
                default:           exc_o = EXC_NONE;
            endcase
        end
    end
endmodule

// File: rtl/pte_perm_checker.sv
// Module: top of the page entry permission checker. Decodes the entry,
// checks rights, computes A/D write-back and the fault class, and
// registers all results one cycle after the input strobe. Assumes one
// entry per strobe; privilege codes 2 and 3 are treated as machine level.
module pte_perm_checker
    import pte_chk_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [FLAG_W-1:0]   pte_flags_i,
    input  logic [ACC_W-1:0]    access_i,
    input  logic [PRIV_W-1:0]   priv_i,
    input  logic                exec_readable_i,
    input  logic                sup_user_i,
    input  logic                upd_en_i,
    input  logic                mem_err_i,
    input  logic                misalign_i,
    output logic                out_valid,
    output logic                invalid_o,
    output logic                pointer_o,
    output logic                allowed_o,
    output logic                need_update_o,
    output logic [FLAG_W-1:0]   new_flags_o,
    output logic [REASON_W-1:0] reason_o,
    output logic [CLASS_W-1:0]  exc_class_o,
    output logic                internal_err_o
);
    acc_e              acc;
    logic              is_user;
    logic              is_mach;
    logic              invalid_c;
    logic              pointer_c;
    logic              permit_c;
    logic              upd_needed_c;
    logic [FLAG_W-1:0] new_flags_c;
    reason_e           reason_c;
    exc_e              exc_c;
    logic              allowed_c;
    logic              need_update_c;

    // Interpret the access and privilege codes.
    always_comb begin
        acc     = acc_e'(access_i);
        is_user = (priv_i == 2'd0);
        is_mach = priv_i[PRIV_W-1];
    end

    pte_flag_decode u_decode (
        .v_i       (pte_flags_i[FB_V]),
        .r_i       (pte_flags_i[FB_R]),
        .w_i       (pte_flags_i[FB_W]),
        .x_i       (pte_flags_i[FB_X]),
        .invalid_o (invalid_c),
        .pointer_o (pointer_c)
    );

    pte_access_rules u_rules (
        .acc_i           (acc),
        .is_user_i       (is_user),
        .exec_readable_i (exec_readable_i),
        .sup_user_i      (sup_user_i),
        .u_i             (pte_flags_i[FB_U]),
        .x_i             (pte_flags_i[FB_X]),
        .w_i             (pte_flags_i[FB_W]),
        .r_i             (pte_flags_i[FB_R]),
        .permit_o        (permit_c)
    );

    pte_dirty_update #(.WIDTH(FLAG_W)) u_dirty (
        .flags_i      (pte_flags_i),
        .acc_i        (acc),
        .upd_needed_o (upd_needed_c),
        .new_flags_o  (new_flags_c)
    );

    pte_fault_select u_fault (
        .acc_i        (acc),
        .mach_i       (is_mach),
        .mem_err_i    (mem_err_i),
        .invalid_i    (invalid_c),
        .pointer_i    (pointer_c),
        .permit_i     (permit_c),
        .misalign_i   (misalign_i),
        .upd_needed_i (upd_needed_c),
        .upd_en_i     (upd_en_i),
        .reason_o     (reason_c),
        .exc_o        (exc_c)
    );

    // Final grant: a leaf at a supported level with no fault.
    always_comb begin
        allowed_c     = !is_mach && !invalid_c && !pointer_c && (reason_c == RSN_NONE);
        need_update_c = allowed_c && upd_needed_c;
    end

    // Result strobe register.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Result registers, loaded on each input strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            invalid_o      <= 1'b0;
            pointer_o      <= 1'b0;
            allowed_o      <= 1'b0;
            need_update_o  <= 1'b0;
            new_flags_o    <= '0;
            reason_o       <= '0;
            exc_class_o    <= '0;
            internal_err_o <= 1'b0;
        end else if (in_valid) begin
            invalid_o      <= invalid_c;
            pointer_o      <= pointer_c;
            allowed_o      <= allowed_c;
            need_update_o  <= need_update_c;
            new_flags_o    <= new_flags_c;
            reason_o       <= reason_c;
            exc_class_o    <= exc_c;
            internal_err_o <= is_mach;
        end
    end

    // R2: the result strobe follows the input strobe by one cycle.
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R9: a granted access carries no fault and is a leaf.
    a_r9_allowed_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && allowed_o) |-> (reason_o == 3'd0 && !invalid_o && !pointer_o));

    // R3: an invalid entry is never granted.
    a_r3_invalid_denied: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && invalid_o) |-> !allowed_o);

    // R10: a class is reported exactly when a reason is.
    a_r10_class_iff_fault: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((reason_o == 3'd0) == (exc_class_o == 3'd0)));

    // R11: machine level is denied and asks for no write-back.
    a_r11_mach_denied: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && internal_err_o) |-> (!allowed_o && !need_update_o && reason_o == 3'd0));

    // R8: a write-back only accompanies a grant and marks the page accessed.
    a_r8_update_marks_a: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && need_update_o) |-> (allowed_o && new_flags_o[FB_A]));
endmodule

// File: tb/pte_perm_checker_bench.sv
`timescale 1ns/1ps
module pte_perm_checker_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] pte_flags_i = '0;
    logic [1:0] access_i = '0;
    logic [1:0] priv_i = '0;
    logic       exec_readable_i = 1'b0;
    logic       sup_user_i = 1'b0;
    logic       upd_en_i = 1'b0;
    logic       mem_err_i = 1'b0;
    logic       misalign_i = 1'b0;
    logic       out_valid;
    logic       invalid_o;
    logic       pointer_o;
    logic       allowed_o;
    logic       need_update_o;
    logic [7:0] new_flags_o;
    logic [2:0] reason_o;
    logic [2:0] exc_class_o;
    logic       internal_err_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int  inv, ptr, alw, upd, nfl, rsn, cls, ierr;
        bit  user, mxr_case;
    } exp_t;

    exp_t exp_q[$];

    always #4 clk = ~clk;

    pte_perm_checker u_pte_perm_checker (
        .clk, .rst_n, .in_valid, .pte_flags_i, .access_i, .priv_i,
        .exec_readable_i, .sup_user_i, .upd_en_i, .mem_err_i, .misalign_i,
        .out_valid, .invalid_o, .pointer_o, .allowed_o, .need_update_o,
        .new_flags_o, .reason_o, .exc_class_o, .internal_err_o
    );

    task automatic chk(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Reference model written from the requirements.
    function automatic exp_t model(int f, int acc, int pv, int mxr, int sum,
                                   int upden, int merr, int mis);
        exp_t e;
        int v, r, w, x, u, a, d, readable, own, perm, store, updn, rsn;
        v = (f >> 0) & 1; r = (f >> 1) & 1; w = (f >> 2) & 1; x = (f >> 3) & 1;
        u = (f >> 4) & 1; a = (f >> 6) & 1; d = (f >> 7) & 1;
        e.inv  = (v == 0 || (w == 1 && r == 0)) ? 1 : 0;
        e.ptr  = (r == 0 && w == 0 && x == 0) ? 1 : 0;
        e.ierr = (pv >= 2) ? 1 : 0;
        e.user = (pv == 0);
        e.mxr_case = (x == 1 && r == 0);
        readable = (r == 1 || (x == 1 && mxr == 1)) ? 1 : 0;
        if (pv == 0) own = u; else own = (u == 0 || sum == 1) ? 1 : 0;
        case (acc)
            0: perm = own & readable;
            1: perm = own & w;
            2: perm = own & w & readable;
            default: perm = ((pv == 0) ? u : (u == 0 ? 1 : 0)) & x;
        endcase
        store = (acc == 1 || acc == 2) ? 1 : 0;
        updn = (a == 0 || (store == 1 && d == 0)) ? 1 : 0;
        e.nfl = f | 64 | (store ? 128 : 0);
        if (e.ierr == 1) rsn = 0;
        else if (merr == 1) rsn = 1;
        else if (e.inv == 1) rsn = 2;
        else if (e.ptr == 1) rsn = 0;
        else if (perm == 0) rsn = 3;
        else if (mis == 1) rsn = 4;
        else if (updn == 1 && upden == 0) rsn = 5;
        else rsn = 0;
        e.rsn = rsn;
        if (rsn == 0) e.cls = 0;
        else if (acc == 0) e.cls = (rsn == 1) ? 1 : 2;
        else if (acc == 3) e.cls = (rsn == 1) ? 5 : 6;
        else e.cls = (rsn == 1) ? 3 : 4;
        e.alw = (e.ierr == 0 && e.inv == 0 && e.ptr == 0 && rsn == 0) ? 1 : 0;
        e.upd = e.alw & updn;
        return e;
    endfunction

    task automatic compare(input exp_t e);
        string ptag;
        if (e.ierr == 1)                       ptag = "R11 allowed";
        else if (e.mxr_case)                   ptag = "R7 allowed";
        else if (e.user)                       ptag = "R5 allowed";
        else                                   ptag = "R6 allowed";
        chk("R3 invalid", invalid_o, e.inv);
        chk("R4 pointer", pointer_o, e.ptr);
        chk(ptag, allowed_o, e.alw);
        chk("R8 need_update", need_update_o, e.upd);
        chk("R8 new_flags", new_flags_o, e.nfl);
        chk("R9 reason", reason_o, e.rsn);
        chk("R10 class", exc_class_o, e.cls);
        chk("R11 internal_err", internal_err_o, e.ierr);
    endtask

    initial begin
        bit prev_valid;
        // R1: reset state.
        repeat (4) @(negedge clk);
        chk("R1 out_valid", out_valid, 0);
        chk("R1 allowed", allowed_o, 0);
        chk("R1 new_flags", new_flags_o, 0);
        chk("R1 reason", reason_o, 0);
        chk("R1 class", exc_class_o, 0);
        rst_n = 1'b1;
        prev_valid = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            int f, acc, pv, mxr, sum, upden, merr, mis, vld;
            @(negedge clk);
            chk("R2 out_valid", out_valid, prev_valid);
            if (prev_valid) compare(exp_q.pop_front());
            f = i % 256; acc = (i / 256) % 4; pv = (i / 1024) % 4;
            mxr = (i / 4096) % 2; sum = (i / 8192) % 2;
            upden = (i % 5 != 0) ? 1 : 0;
            merr  = (i % 37 == 5) ? 1 : 0;
            mis   = (i % 11 == 3) ? 1 : 0;
            vld   = (i % 13 != 0) ? 1 : 0;
            pte_flags_i = f[7:0]; access_i = acc[1:0]; priv_i = pv[1:0];
            exec_readable_i = mxr[0]; sup_user_i = sum[0]; upd_en_i = upden[0];
            mem_err_i = merr[0]; misalign_i = mis[0]; in_valid = vld[0];
            if (vld == 1) exp_q.push_back(model(f, acc, pv, mxr, sum, upden, merr, mis));
            prev_valid = vld[0];
        end
        @(negedge clk);
        chk("R2 out_valid", out_valid, prev_valid);
        if (prev_valid) compare(exp_q.pop_front());
        in_valid = 1'b0;
        @(negedge clk);
        chk("R2 out_valid idle", out_valid, 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule